// File: doc/BRIEF.md
# Serial Loopback and Bit-Timing Router

This block serializes parallel transmit words, deserializes a received serial stream into parallel words, and routes both streams through a set of loopback and timing modes for link diagnostics. Bit timing comes from a single system clock qualified by two bit-rate strobes. One strobe is derived from the reference and the other stands in for the recovered receive clock. The analog clock recovery and the frequency multiplier sit outside the block.

The transmit side shifts each captured word onto the serial line most significant bit first. The receive side fills a word from the serial bits, with the first bit received landing in bit 15. Each side has a word clock that runs at one sixteenth of its bit rate. Three loopback controls pick the serial output and the deserializer source, with a fixed precedence between them. A fourth control moves the transmit bit timing onto the recovered strobe. A registered fault flag reports a lost signal except during diagnostic loopback.

Top module: `serdes_lb_ctrl`

## Requirements
- R1: While reset is low, ser_out is 0 (no loopback selected), rx_word is 0, both word clocks are 0 and link_fault is 0.
- R2: In normal output mode, the word on tx_word is captured on the transmit bit strobe at which tx_word_clk rises. Its bit 15 appears on ser_out in the cycle after that edge, and the following bits come out in descending order, one per transmit bit strobe.
- R3: tx_word_clk is high for the first 8 transmit bit times of each word and low for the last 8, so its period is 16 transmit bit times.
- R4: On each rec_bit_en, the deserializer samples its source bit. The first of 16 samples lands in rx_word bit 15. rx_word changes only on the rising edge of rx_word_clk, which is high for 8 and low for 8 bit times.
- R5: When diag_lb is 1, the deserializer takes the transmit serial stream instead of ser_in and is timed by the transmit bit strobe. Transmit word N then appears on rx_word one word period after it was captured.
- R6: When line_lb_rt is 1, ser_out is the value of ser_in sampled at the most recent rec_bit_en. The deserializer keeps receiving ser_in at the same time.
- R7: When line_lb_rt is 0 and line_lb_raw is 1, ser_out equals ser_in in the same cycle, with no register in the path.
- R8: The serial output source follows a fixed precedence: retimed loopback first, then raw loopback, then the transmit shifter.
- R9: When loop_time is 1, the transmitter advances on rec_bit_en. When loop_time is 0, it advances on ref_bit_en.
- R10: link_fault is registered. It is 1 one cycle after sig_det is 0 while diag_lb is 0. sig_det has no effect while diag_lb is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_bit_en | input | 1 | Reference-derived transmit bit strobe |
| rec_bit_en | input | 1 | Recovered receive bit strobe |
| tx_word | input | 16 | Parallel transmit word |
| ser_in | input | 1 | Received serial bit |
| sig_det | input | 1 | Signal present on the line |
| diag_lb | input | 1 | Diagnostic loopback: transmit stream feeds the deserializer |
| line_lb_rt | input | 1 | Retimed line loopback to ser_out |
| line_lb_raw | input | 1 | Unretimed line loopback to ser_out |
| loop_time | input | 1 | Transmit bit timing from the recovered strobe |
| ser_out | output | 1 | Serial output bit |
| tx_word_clk | output | 1 | Transmit word clock, bit rate divided by 16 |
| rx_word | output | 16 | Parallel received word |
| rx_word_clk | output | 1 | Receive word clock, bit rate divided by 16 |
| link_fault | output | 1 | Signal lost outside diagnostic loopback |

## Verification
The bench checks bit order and word boundaries in every output mode. A design that shifts LSB first, or that is off by one bit in its word alignment, shows a corrupted word on rx_word or the wrong bit on ser_out. It turns on both line loopbacks together: a design with the precedence swapped shows the current ser_in bit where the bench expects the previous one. It also measures the transmit word clock period with loop timing on a slower recovered strobe, and the fault flag with signal loss inside and outside diagnostic loopback. A wrong clock selection or an ignored mode gate shows up directly in those measurements.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

    typedef enum logic [1:0] {
        SRC_TX      = 2'd0,
        SRC_RAW     = 2'd1,
        SRC_RETIMED = 2'd2
    } ser_src_e;

    // Retimed loopback wins over raw loopback, which wins over transmit data.
    function automatic ser_src_e pick_src(input logic rt, input logic raw);
        if (rt)       return SRC_RETIMED;
        else if (raw) return SRC_RAW;
        else          return SRC_TX;
    endfunction

endpackage

// File: rtl/slb_tx_shift.sv
module slb_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic [W-1:0] par_in,
    output logic         ser_bit,
    output logic         word_clk
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (st_q.cnt == CW'(W-1)) begin
                st_d.sh  = par_in;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = {st_q.sh[W-2:0], 1'b0};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= CW'(W-1);
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit  = st_q.sh[W-1];
    assign word_clk = (st_q.cnt < CW'(W/2));

endmodule

// File: rtl/slb_rx_shift.sv
module slb_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         src_bit,
    input  logic         rt_en,
    input  logic         line_in,
    output logic [W-1:0] par_out,
    output logic         word_clk,
    output logic         rt_bit
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          rt;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            st_d.sh = {st_q.sh[W-2:0], src_bit};
            if (st_q.cnt == CW'(W-1)) begin
                st_d.word = {st_q.sh[W-2:0], src_bit};
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
        if (rt_en) begin
            st_d.rt = line_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.word <= '0;
            st_q.cnt  <= CW'(W-1);
            st_q.rt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_out  = st_q.word;
    assign word_clk = (st_q.cnt < CW'(W/2));
    assign rt_bit   = st_q.rt;

endmodule

// File: rtl/slb_route.sv
module slb_route
    import serdes_lb_pkg::*;
(
    input  logic diag_lb,
    input  logic line_lb_rt,
    input  logic line_lb_raw,
    input  logic loop_time,
    input  logic ref_bit_en,
    input  logic rec_bit_en,
    input  logic tx_bit,
    input  logic rt_bit,
    input  logic ser_in,
    output logic tx_en,
    output logic rx_en,
    output logic rx_src,
    output logic ser_out
);
    ser_src_e out_sel;

    always_comb begin
        tx_en   = loop_time ? rec_bit_en : ref_bit_en;
        rx_en   = diag_lb ? tx_en : rec_bit_en;
        rx_src  = diag_lb ? tx_bit : ser_in;
        out_sel = pick_src(line_lb_rt, line_lb_raw);
        unique case (out_sel)
            SRC_RETIMED: ser_out = rt_bit;
            SRC_RAW:     ser_out = ser_in;
            default:     ser_out = tx_bit;
        endcase
    end

endmodule

// File: rtl/serdes_lb_ctrl.sv
module serdes_lb_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_bit_en,
    input  logic         rec_bit_en,
    input  logic [W-1:0] tx_word,
    input  logic         ser_in,
    input  logic         sig_det,
    input  logic         diag_lb,
    input  logic         line_lb_rt,
    input  logic         line_lb_raw,
    input  logic         loop_time,
    output logic         ser_out,
    output logic         tx_word_clk,
    output logic [W-1:0] rx_word,
    output logic         rx_word_clk,
    output logic         link_fault
);
    logic tx_en, rx_en, rx_src, tx_bit, rt_bit;

    typedef struct packed {
        logic fault;
    } top_st_t;

    top_st_t st_d, st_q;

    slb_route u_route (
        .diag_lb     (diag_lb),
        .line_lb_rt  (line_lb_rt),
        .line_lb_raw (line_lb_raw),
        .loop_time   (loop_time),
        .ref_bit_en  (ref_bit_en),
        .rec_bit_en  (rec_bit_en),
        .tx_bit      (tx_bit),
        .rt_bit      (rt_bit),
        .ser_in      (ser_in),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .rx_src      (rx_src),
        .ser_out     (ser_out)
    );

    slb_tx_shift #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (tx_en),
        .par_in   (tx_word),
        .ser_bit  (tx_bit),
        .word_clk (tx_word_clk)
    );

    slb_rx_shift #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (rx_en),
        .src_bit  (rx_src),
        .rt_en    (rec_bit_en),
        .line_in  (ser_in),
        .par_out  (rx_word),
        .word_clk (rx_word_clk),
        .rt_bit   (rt_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = !sig_det && !diag_lb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_fault = st_q.fault;

endmodule

// File: rtl/serdes_lb_chk.sv
module serdes_lb_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ref_bit_en,
    input logic         rec_bit_en,
    input logic         ser_in,
    input logic         sig_det,
    input logic         diag_lb,
    input logic         line_lb_rt,
    input logic         line_lb_raw,
    input logic         loop_time,
    input logic         ser_out,
    input logic         tx_word_clk,
    input logic [W-1:0] rx_word,
    input logic         rx_word_clk,
    input logic         link_fault
);
    logic sel_en;
    assign sel_en = loop_time ? rec_bit_en : ref_bit_en;

    a_r3_word_clk_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_word_clk) && $past(rst_n)) |-> $past(sel_en));

    a_r4_word_on_clk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_word) && $past(rst_n)) |-> $rose(rx_word_clk));

    a_r6_retimed_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (line_lb_rt && $past(line_lb_rt && rec_bit_en) && $past(rst_n))
        |-> (ser_out == $past(ser_in)));

    a_r7_raw_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_lb_rt && line_lb_raw) |-> (ser_out == ser_in));

    a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_lb_rt && !line_lb_raw && $past(!line_lb_rt && !line_lb_raw)
         && $past(rst_n) && !$past(sel_en)) |-> $stable(ser_out));

    a_r10_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (link_fault == $past(!sig_det && !diag_lb)));

endmodule

bind serdes_lb_ctrl serdes_lb_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_bit_en  (ref_bit_en),
    .rec_bit_en  (rec_bit_en),
    .ser_in      (ser_in),
    .sig_det     (sig_det),
    .diag_lb     (diag_lb),
    .line_lb_rt  (line_lb_rt),
    .line_lb_raw (line_lb_raw),
    .loop_time   (loop_time),
    .ser_out     (ser_out),
    .tx_word_clk (tx_word_clk),
    .rx_word     (rx_word),
    .rx_word_clk (rx_word_clk),
    .link_fault  (link_fault)
);

// File: tb/serdes_lb_ctrl_bench.sv
`timescale 1ns/1ps
module serdes_lb_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_bit_en = 1'b1, rec_bit_en = 1'b1;
    logic [15:0] tx_word = '0;
    logic        ser_in = 1'b0, sig_det = 1'b0;
    logic        diag_lb = 1'b0, line_lb_rt = 1'b0, line_lb_raw = 1'b0, loop_time = 1'b0;
    logic        ser_out, tx_word_clk, rx_word_clk, link_fault;
    logic [15:0] rx_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    serdes_lb_ctrl u_serdes_lb_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_bit_en(ref_bit_en), .rec_bit_en(rec_bit_en),
        .tx_word(tx_word), .ser_in(ser_in), .sig_det(sig_det), .diag_lb(diag_lb),
        .line_lb_rt(line_lb_rt), .line_lb_raw(line_lb_raw), .loop_time(loop_time),
        .ser_out(ser_out), .tx_word_clk(tx_word_clk), .rx_word(rx_word),
        .rx_word_clk(rx_word_clk), .link_fault(link_fault)
    );

    function automatic logic [15:0] txw(input int i);
        if (i % 7 == 1) return 16'hFFFF;
        if (i % 7 == 2) return 16'h0000;
        return 16'(32'h8001 + i * 32'h3B5D);
    endfunction

    function automatic logic [15:0] rxw(input int i);
        if (i % 5 == 3) return 16'h8000;
        return 16'(32'h1234 ^ (i * 32'h6F1B));
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [15:0] first_word);
        rst_n = 1'b0;
        ref_bit_en = 1'b1;
        rec_bit_en = 1'b1;
        ser_in = 1'b0;
        tx_word = first_word;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs nw words with both strobes active every cycle, right after reset.
    task automatic run_words(input int nw, input int base, input logic dg,
                             input logic rt, input logic raw);
        logic prev_in;
        diag_lb = dg; line_lb_rt = rt; line_lb_raw = raw;
        do_reset(txw(base));
        for (int i = 0; i < nw; i++) begin
            for (int n = 0; n < 16; n++) begin
                @(posedge clk);
                @(negedge clk);
                prev_in = ser_in;
                if (n == 0) begin
                    tx_word = txw(base + i + 1);
                    if (i == 0)  chk("R4 first word", rx_word, 16'h0000);
                    else if (dg) chk("R5 diag word", rx_word, txw(base + i - 1));
                    else         chk("R4 rx word", rx_word, rxw(base + i - 1));
                end
                chk("R3 tx word clk", {15'd0, tx_word_clk}, {15'd0, (n < 8)});
                chk("R4 rx word clk", {15'd0, rx_word_clk}, {15'd0, (n < 8)});
                if (rt)       chk("R6 R8 retimed out", {15'd0, ser_out}, {15'd0, prev_in});
                else if (!raw) chk("R2 tx bit", {15'd0, ser_out}, {15'd0, txw(base + i)[15-n]});
                ser_in = dg ? ~rxw(base + i)[15-n] : rxw(base + i)[15-n];
                if (raw && !rt) begin
                    #1;
                    chk("R7 raw out", {15'd0, ser_out}, {15'd0, ser_in});
                end
            end
        end
    endtask

    // Cycles between successive tx_word_clk rises, recovered strobe every div cycles.
    task automatic measure(input int div, output int period);
        int c = 0, r1 = -1, r2 = -1;
        logic prev_wc = tx_word_clk;
        period = -1;
        while (c < 600 && r2 < 0) begin
            rec_bit_en = ((c % div) == 0);
            @(posedge clk);
            @(negedge clk);
            c++;
            if (tx_word_clk && !prev_wc) begin
                if (r1 < 0) r1 = c;
                else        r2 = c;
            end
            prev_wc = tx_word_clk;
        end
        if (r2 >= 0) period = r2 - r1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int per;
        // R1: reset values, with fault conditions present
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ser_out", {15'd0, ser_out}, 16'd0);
        chk("R1 rx_word", rx_word, 16'd0);
        chk("R1 tx_word_clk", {15'd0, tx_word_clk}, 16'd0);
        chk("R1 rx_word_clk", {15'd0, rx_word_clk}, 16'd0);
        chk("R1 link_fault", {15'd0, link_fault}, 16'd0);
        sig_det = 1'b1;

        run_words(5, 0, 1'b0, 1'b0, 1'b0);   // normal transmit and receive
        run_words(5, 10, 1'b1, 1'b0, 1'b0);  // diagnostic loopback
        run_words(4, 20, 1'b0, 1'b1, 1'b0);  // retimed loopback
        run_words(4, 30, 1'b0, 1'b0, 1'b1);  // raw loopback
        run_words(4, 40, 1'b0, 1'b1, 1'b1);  // both: retimed wins (R8)

        // R9: transmit bit timing source
        diag_lb = 1'b0; line_lb_rt = 1'b0; line_lb_raw = 1'b0;
        loop_time = 1'b1;
        do_reset(16'h0F0F);
        measure(3, per);
        chk("R9 loop-time period", 16'(per), 16'd48);
        loop_time = 1'b0;
        measure(3, per);
        measure(3, per);
        chk("R9 reference period", 16'(per), 16'd16);
        rec_bit_en = 1'b1;

        // R10: fault flag and its gating by diagnostic loopback
        sig_det = 1'b0; diag_lb = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 fault raised", {15'd0, link_fault}, 16'd1);
        diag_lb = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 sig_det ignored in diag", {15'd0, link_fault}, 16'd0);
        diag_lb = 1'b0; sig_det = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 fault clear", {15'd0, link_fault}, 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule